// File: doc/BRIEF.md
# Cache Maintenance Operation Sequencer

This block executes maintenance commands against the tag state of a set-associative cache. A command carries four fields: an operation (invalidate or push), a scope (one line, one 4 KB physical page, or the whole cache), a target cache (data or instruction) and an address. Once the block accepts a command, it steps a line pointer over the affected set/way positions and reads the tag, valid and dirty state of each one through a combinational lookup port.

Every valid line that falls inside the scope is selected. Under a push to the data cache, a selected line that is dirty is first read word by word through the same lookup pointer. It is then offered as one line-write request, which carries the line address and four words. The line is invalidated only once that request is acknowledged. Every other selected line is invalidated with no write-back. Invalidation appears as a one-cycle strobe naming the cache, set and way, and the owner of the tag array clears the line's state on that strobe. A one-cycle done pulse ends the command.

Top module: `cmo_seq`

## Requirements
- R1: After reset, busy_o, done_o, inv_o and wb_req_o are all low.
- R2: A command presented with cmd_valid_i while idle raises busy_o in the next cycle. busy_o stays high until a single-cycle done_o pulse, and drops in the cycle after that pulse.
- R3: cmd_valid_i is ignored while busy_o is high. The running command completes unchanged, and the ignored command invalidates nothing and writes nothing back.
- R4: Operation code 0 (invalidate) strobes inv_o once for each selected line and never raises wb_req_o.
- R5: Scope code 0 (line) selects only the valid ways in set addr[7:4] whose tag equals addr[31:8], with 16-byte lines and 16 sets.
- R6: Scope code 1 (page) selects every valid line whose line address bits [31:12] equal addr[31:12].
- R7: Scope codes 2 and 3 (whole cache) select every valid line. For all scopes, lines are visited in ascending set order with ways ascending inside each set, and the inv_o strobes follow that order.
- R8: Operation code 1 (push) on the data cache (cache code 0) writes back each selected dirty line before invalidating it. wb_addr_o is {tag, set, 4'h0}. Word i of the line is read with rd_word_o=i and lands in wb_data_o[32i+31:32i]. wb_req_o and its payload are held until wb_ack_i, and inv_o for that line follows in the next cycle. Clean selected lines are invalidated with no request.
- R9: A push to the instruction cache (cache code 1) performs invalidation only and never raises wb_req_o.
- R10: lookup_cache_o follows the command's cache code for the whole command, so the other cache's lines are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_op_i | input | 1 | 0 invalidate, 1 push |
| cmd_scope_i | input | 2 | 0 line, 1 page, 2/3 whole cache |
| cmd_cache_i | input | 1 | 0 data cache, 1 instruction cache |
| cmd_addr_i | input | 32 | Physical address for line/page scope |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| lookup_cache_o | output | 1 | Cache selected by lookup pointer |
| lookup_set_o | output | 4 | Set index of lookup pointer |
| lookup_way_o | output | 2 | Way of lookup pointer |
| rd_word_o | output | 2 | Word index for line data read |
| tag_valid_i | input | 1 | Valid bit at lookup pointer |
| tag_dirty_i | input | 1 | Dirty bit at lookup pointer |
| tag_i | input | 24 | Tag at lookup pointer |
| rd_data_i | input | 32 | Line word at pointer and rd_word_o |
| inv_o | output | 1 | Invalidate strobe for pointed line |
| wb_req_o | output | 1 | Line write-back request |
| wb_addr_o | output | 32 | Write-back line address |
| wb_data_o | output | 128 | Write-back line data, word 0 lowest |
| wb_ack_i | input | 1 | Write-back acknowledge |

## Verification
A wrong pointer or a wrong scope decision shows up at the ports as an inv_o strobe naming an unexpected set/way, or as a strobe missing from the ordered sequence. The bench compares that sequence against its own walk when done_o fires. A corrupted dirty or operation state shows up as a missing or extra wb_req_o, or a wrong address or data in the write-back. An early release of the request is caught in the very next cycle. A broken idle/busy control shows up within one cycle of the command or of done_o, through the busy_o timing checks.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_READ, ST_WB, ST_INV, ST_DONE
  } cmo_state_e;

  localparam logic [1:0] SC_LINE = 2'd0;
  localparam logic [1:0] SC_PAGE = 2'd1;
  localparam logic OP_INV  = 1'b0;
  localparam logic OP_PUSH = 1'b1;
  localparam logic CACHE_D = 1'b0;
  localparam logic CACHE_I = 1'b1;
endpackage

// File: rtl/cmo_walker.sv
module cmo_walker #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int IDX_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fix_set_i,
  input  logic [IDX_W-1:0] set_init_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] set_o,
  output logic [WAY_W-1:0] way_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] SET_MAX = IDX_W'(SETS - 1);
  localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(WAYS - 1);

  logic [IDX_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;
  logic             fix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
      way_q <= '0;
      fix_q <= 1'b0;
    end else if (start_i) begin
      set_q <= fix_set_i ? set_init_i : '0;
      way_q <= '0;
      fix_q <= fix_set_i;
    end else if (step_i) begin
      if (way_q == WAY_MAX) begin
        way_q <= '0;
        set_q <= set_q + 1'b1;
      end else begin
        way_q <= way_q + 1'b1;
      end
    end
  end

  assign set_o  = set_q;
  assign way_o  = way_q;
  // line scope stays inside one set
  assign last_o = (way_q == WAY_MAX) && (fix_q || set_q == SET_MAX);
endmodule

// File: rtl/cmo_line_sel.sv
module cmo_line_sel
  import cmo_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 4,
  parameter int IDX_W     = 4,
  parameter int PAGE_BITS = 12,
  parameter int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
  input  logic [1:0]            scope_i,
  input  logic [ADDR_W-1:OFF_W] addr_hi_i,
  input  logic [IDX_W-1:0]      set_i,
  input  logic [TAG_W-1:0]      tag_i,
  input  logic                  valid_i,
  output logic                  hit_o
);
  localparam int HI_W = ADDR_W - OFF_W;

  logic [HI_W-1:0] line_hi;
  logic            in_scope;

  assign line_hi = {tag_i, set_i};

  always_comb begin
    case (scope_i)
      SC_LINE: in_scope = (line_hi == addr_hi_i);
      SC_PAGE: in_scope = (line_hi[HI_W-1:PAGE_BITS-OFF_W] == addr_hi_i[ADDR_W-1:PAGE_BITS]);
      default: in_scope = 1'b1;
    endcase
  end

  assign hit_o = valid_i && in_scope;
endmodule

// File: rtl/cmo_wb_buf.sv
module cmo_wb_buf #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WRD_W      = $clog2(LINE_WORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cap_i,
  input  logic [WRD_W-1:0]             idx_i,
  input  logic [WORD_W-1:0]            data_i,
  output logic [LINE_WORDS*WORD_W-1:0] line_o
);
  logic [LINE_WORDS-1:0][WORD_W-1:0] word_q;

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              word_q[g] <= '0;
      else if (cap_i && idx_i == WRD_W'(g))     word_q[g] <= data_i;
    end
  end

  assign line_o = word_q;
endmodule

// File: rtl/cmo_seq.sv
module cmo_seq
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int PAGE_BITS  = 12,
  localparam int OFF_W  = $clog2(LINE_WORDS * WORD_W / 8),
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WRD_W  = $clog2(LINE_WORDS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = LINE_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_op_i,
  input  logic [1:0]        cmd_scope_i,
  input  logic              cmd_cache_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              lookup_cache_o,
  output logic [IDX_W-1:0]  lookup_set_o,
  output logic [WAY_W-1:0]  lookup_way_o,
  output logic [WRD_W-1:0]  rd_word_o,
  input  logic              tag_valid_i,
  input  logic              tag_dirty_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              inv_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [LINE_W-1:0] wb_data_o,
  input  logic              wb_ack_i
);
  cmo_state_e            state_q, state_d;
  logic                  op_q, cache_q;
  logic [1:0]            scope_q;
  logic [ADDR_W-1:OFF_W] addr_hi_q;
  logic [TAG_W-1:0]      tag_q;
  logic [WRD_W-1:0]      word_q;
  logic                  walk_start, walk_step, last, hit, need_wb;
  logic                  unused_addr;

  assign unused_addr = ^cmd_addr_i[OFF_W-1:0];

  assign walk_start = (state_q == ST_IDLE) && cmd_valid_i;
  assign need_wb    = (op_q == OP_PUSH) && (cache_q == CACHE_D) && tag_dirty_i;

  cmo_walker #(.SETS(SETS), .WAYS(WAYS)) walker_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (walk_start),
    .fix_set_i  (cmd_scope_i == SC_LINE),
    .set_init_i (cmd_addr_i[OFF_W +: IDX_W]),
    .step_i     (walk_step),
    .set_o      (lookup_set_o),
    .way_o      (lookup_way_o),
    .last_o     (last)
  );

  cmo_line_sel #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PAGE_BITS(PAGE_BITS)
  ) sel_i (
    .scope_i   (scope_q),
    .addr_hi_i (addr_hi_q),
    .set_i     (lookup_set_o),
    .tag_i     (tag_i),
    .valid_i   (tag_valid_i),
    .hit_o     (hit)
  );

  cmo_wb_buf #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) buf_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (state_q == ST_READ),
    .idx_i  (word_q),
    .data_i (rd_data_i),
    .line_o (wb_data_o)
  );

  always_comb begin
    state_d   = state_q;
    walk_step = 1'b0;
    case (state_q)
      ST_IDLE: if (cmd_valid_i) state_d = ST_SCAN;
      ST_SCAN: begin
        if (hit)       state_d = need_wb ? ST_READ : ST_INV;
        else if (last) state_d = ST_DONE;
        else           walk_step = 1'b1;
      end
      ST_READ: if (word_q == WRD_W'(LINE_WORDS - 1)) state_d = ST_WB;
      ST_WB:   if (wb_ack_i) state_d = ST_INV;
      ST_INV: begin
        if (last) state_d = ST_DONE;
        else begin
          walk_step = 1'b1;
          state_d   = ST_SCAN;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_INV;
      cache_q   <= CACHE_D;
      scope_q   <= SC_LINE;
      addr_hi_q <= '0;
      tag_q     <= '0;
      word_q    <= '0;
    end else begin
      state_q <= state_d;
      if (walk_start) begin
        op_q      <= cmd_op_i;
        cache_q   <= cmd_cache_i;
        scope_q   <= cmd_scope_i;
        addr_hi_q <= cmd_addr_i[ADDR_W-1:OFF_W];
      end
      if (state_q == ST_SCAN && hit && need_wb) begin
        tag_q  <= tag_i;
        word_q <= '0;
      end else if (state_q == ST_READ) begin
        word_q <= word_q + 1'b1;
      end
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = (state_q == ST_DONE);
  assign inv_o          = (state_q == ST_INV);
  assign wb_req_o       = (state_q == ST_WB);
  assign lookup_cache_o = cache_q;
  assign rd_word_o      = word_q;
  assign wb_addr_o      = {tag_q, lookup_set_o, {OFF_W{1'b0}}};
endmodule

// File: rtl/cmo_seq_chk.sv
module cmo_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4,
  parameter int LINE_W = 128
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cmd_valid_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  inv_o,
  input logic                  wb_req_o,
  input logic                  wb_ack_i,
  input logic [ADDR_W-1:0]     wb_addr_o,
  input logic [LINE_W-1:0]     wb_data_o,
  input logic [IDX_W-1:0]      lookup_set_o,
  input logic                  op_q,
  input logic                  cache_q,
  input logic [1:0]            scope_q,
  input logic [ADDR_W-1:OFF_W] addr_hi_q
);
  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_valid_i |=> busy_o);
  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);
  // R3
  cmd_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(op_q) && $stable(cache_q) && $stable(scope_q) && $stable(addr_hi_q));
  // R4
  inv_in_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> busy_o && !wb_req_o && !done_o);
  // R4
  wb_push_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> op_q);
  // R9
  wb_dcache_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> !cache_q);
  // R5
  line_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && scope_q == 2'd0 |-> lookup_set_o == addr_hi_q[OFF_W +: IDX_W]);
  // R8
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_addr_o) && $stable(wb_data_o));
  // R8
  wb_then_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && wb_ack_i |=> inv_o);
endmodule

bind cmo_seq cmo_seq_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LINE_W(LINE_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .inv_o        (inv_o),
  .wb_req_o     (wb_req_o),
  .wb_ack_i     (wb_ack_i),
  .wb_addr_o    (wb_addr_o),
  .wb_data_o    (wb_data_o),
  .lookup_set_o (lookup_set_o),
  .op_q         (op_q),
  .cache_q      (cache_q),
  .scope_q      (scope_q),
  .addr_hi_q    (addr_hi_q)
);

// File: tb/cmo_seq_tb_top.sv
`timescale 1ns/1ps
module cmo_seq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0, cmd_op = 1'b0, cmd_cache = 1'b0;
  logic [1:0]   cmd_scope = 2'd0;
  logic [31:0]  cmd_addr = '0;
  logic         busy, done, lk_cache, inv, wb_req;
  logic [3:0]   lk_set;
  logic [1:0]   lk_way, rd_word;
  logic         t_valid, t_dirty;
  logic [23:0]  t_tag;
  logic [31:0]  rd_data, wb_addr;
  logic [127:0] wb_data;
  logic         wb_ack = 1'b0;

  int n_run = 0, n_fail = 0;
  int ack_dly = 0;

  bit          mv [2][16][4];
  bit          md [2][16][4];
  logic [23:0] mt [2][16][4];
  bit          ev [2][16][4];
  bit          ed [2][16][4];
  logic [19:0] pages [2] = '{20'hABCDE, 20'h12345};

  logic [6:0]   exp_inv[$], got_inv[$];
  logic [159:0] exp_wb[$],  got_wb[$];

  always #4 clk = ~clk;

  cmo_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_scope_i(cmd_scope), .cmd_cache_i(cmd_cache), .cmd_addr_i(cmd_addr),
    .busy_o(busy), .done_o(done), .lookup_cache_o(lk_cache), .lookup_set_o(lk_set),
    .lookup_way_o(lk_way), .rd_word_o(rd_word), .tag_valid_i(t_valid),
    .tag_dirty_i(t_dirty), .tag_i(t_tag), .rd_data_i(rd_data), .inv_o(inv),
    .wb_req_o(wb_req), .wb_addr_o(wb_addr), .wb_data_o(wb_data), .wb_ack_i(wb_ack)
  );

  function automatic logic [31:0] word_of(int s, int w, int i);
    return 32'hC000_0000 | (s << 16) | (w << 8) | i;
  endfunction

  // tag/data array model
  always_comb begin
    t_valid = mv[lk_cache][lk_set][lk_way];
    t_dirty = md[lk_cache][lk_set][lk_way];
    t_tag   = mt[lk_cache][lk_set][lk_way];
    rd_data = word_of(int'(lk_set), int'(lk_way), int'(rd_word));
  end

  always @(posedge clk) if (inv) begin
    mv[lk_cache][lk_set][lk_way] <= 1'b0;
    md[lk_cache][lk_set][lk_way] <= 1'b0;
  end

  // monitor and write-back responder
  always @(negedge clk) if (rst_n) begin
    if (inv) got_inv.push_back({lk_cache, lk_set, lk_way});
    if (wb_ack) wb_ack = 1'b0;
    else if (wb_req) begin
      if (ack_dly == 0) begin
        wb_ack = 1'b1;
        got_wb.push_back({wb_addr, wb_data});
        ack_dly = $urandom % 4;
      end else ack_dly--;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill();
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 16; s++)
        for (int w = 0; w < 4; w++) begin
          mv[c][s][w] = 1'($urandom);
          md[c][s][w] = (c == 0) ? (mv[c][s][w] & 1'($urandom)) : 1'b0;
          mt[c][s][w] = {pages[$urandom % 2], 4'($urandom)};
        end
  endtask

  task automatic predict(input logic op, input logic [1:0] sc, input logic c,
                         input logic [31:0] a);
    exp_inv.delete();
    exp_wb.delete();
    ev = mv;
    ed = md;
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        bit m;
        case (sc)
          2'd0:    m = (4'(s) == a[7:4]) && (mt[c][s][w] == a[31:8]);
          2'd1:    m = (mt[c][s][w][23:4] == a[31:12]);
          default: m = 1'b1;
        endcase
        if (mv[c][s][w] && m) begin
          if (op && !c && md[c][s][w])
            exp_wb.push_back({mt[c][s][w], 4'(s), 4'h0,
                              word_of(s, w, 3), word_of(s, w, 2),
                              word_of(s, w, 1), word_of(s, w, 0)});
          exp_inv.push_back({c, 4'(s), 2'(w)});
          ev[c][s][w] = 1'b0;
          ed[c][s][w] = 1'b0;
        end
      end
  endtask

  task automatic run_cmd(input logic op, input logic [1:0] sc, input logic c,
                         input logic [31:0] a, input bit inject);
    int cyc = 0;
    int bad = 0;
    string rq;
    predict(op, sc, c, a);
    got_inv.delete();
    got_wb.delete();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_scope = sc; cmd_cache = c; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy === 1'b1, "R2", "busy after accept", 160'(busy), 160'(1));
    while (done !== 1'b1 && cyc < 5000) begin
      if (inject && cyc == 1 && busy && !done) begin
        // R3: foreign command while busy
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_scope = 2'd2; cmd_cache = ~c;
      end else cmd_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    check(done === 1'b1, "R2", "done seen", 160'(done), 160'(1));
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R2", "idle after done", 160'({busy, done}), 160'(0));
    rq = (sc == 2'd0) ? "R5" : (sc == 2'd1) ? "R6" : "R7";
    check(got_inv.size() == exp_inv.size(), rq, "inv count", 160'(got_inv.size()), 160'(exp_inv.size()));
    for (int i = 0; i < got_inv.size() && i < exp_inv.size(); i++)
      check(got_inv[i] == exp_inv[i], rq, "inv line/order", 160'(got_inv[i]), 160'(exp_inv[i]));
    rq = !op ? "R4" : c ? "R9" : "R8";
    check(got_wb.size() == exp_wb.size(), rq, "wb count", 160'(got_wb.size()), 160'(exp_wb.size()));
    for (int i = 0; i < got_wb.size() && i < exp_wb.size(); i++)
      check(got_wb[i] == exp_wb[i], "R8", "wb addr/data", got_wb[i], exp_wb[i]);
    for (int cc = 0; cc < 2; cc++)
      for (int s = 0; s < 16; s++)
        for (int w = 0; w < 4; w++)
          if (mv[cc][s][w] != ev[cc][s][w] || md[cc][s][w] != ed[cc][s][w]) bad++;
    check(bad == 0, inject ? "R3" : "R10", "final line state mismatches", 160'(bad), 160'(0));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    fill();
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && inv === 1'b0 && wb_req === 1'b0, "R1",
          "outputs in reset", 160'({busy, done, inv, wb_req}), 160'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && inv === 1'b0 && wb_req === 1'b0, "R1",
          "outputs after reset", 160'({busy, done, inv, wb_req}), 160'(0));

    // R5 directed line hit, dirty line, invalidate only (R4)
    mv[0][5][2] = 1; md[0][5][2] = 1; mt[0][5][2] = 24'hABCDE3;
    run_cmd(1'b0, 2'd0, 1'b0, {24'hABCDE3, 4'd5, 4'h8}, 0);
    // R8 directed line push of a dirty line
    fill();
    mv[0][9][1] = 1; md[0][9][1] = 1; mt[0][9][1] = 24'h12345A;
    run_cmd(1'b1, 2'd0, 1'b0, {24'h12345A, 4'd9, 4'h0}, 0);
    // R6 page push on data cache
    run_cmd(1'b1, 2'd1, 1'b0, {20'hABCDE, 12'h000}, 0);
    // R9 whole push on instruction cache
    fill();
    run_cmd(1'b1, 2'd2, 1'b1, 32'h0, 0);
    // R7 scope code 3 whole push on data cache
    fill();
    run_cmd(1'b1, 2'd3, 1'b0, 32'h0, 0);
    // R3 ignored command while busy
    fill();
    run_cmd(1'b1, 2'd2, 1'b0, 32'h0, 1);
    // R5 line miss: nothing selected
    run_cmd(1'b1, 2'd0, 1'b0, 32'hFFFF_FFF0, 0);

    for (int k = 0; k < 40; k++) begin
      logic        op, c;
      logic [1:0]  sc;
      logic [31:0] a;
      if (k % 4 == 0) fill();
      op = 1'($urandom); c = 1'($urandom); sc = 2'($urandom);
      a  = {pages[$urandom % 2], 12'($urandom)};
      if ($urandom % 2 == 1) begin
        int s = $urandom % 16;
        int w = $urandom % 4;
        a = {mt[c][s][w], 4'(s), 4'($urandom)};
      end
      run_cmd(op, sc, c, a, k % 7 == 3);
    end

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule